// File: doc/BRIEF.md
# Prioritized Update Register Field

This block is the storage of one field inside a memory-mapped register. Each cycle it selects the field's next value from a set of update rules, split into a software group and a hardware group. The software group covers read side effects, a write rule chosen at build time, and a self-clearing pulse mode. The hardware group covers a set, a clear and a data write path with a configurable enable. A build-time precedence setting decides which group is evaluated first. Only the single winning rule updates the field. When no rule is active, the field keeps its value.

The block sits behind an address decoder. It receives the decoded hit, the request direction, and the full-width write data and bit enables. It takes its field slice from those buses. It returns the stored value and four strobes: access, read access, write access and modify.

The selection logic is a small set of named rule sources. These are HOLD, RDFX (read side effect), WRITE (software write rule), PULSE (self-clear), HSET (hardware set), HCLR (hardware clear) and HWR (hardware data write). The register takes the value of the winning source on each clock edge. The possible transitions are: any source to any source, HOLD to HOLD when idle, and reset to HOLD.

Top module: `prio_field`

## Requirements
- R1: With `SW_FIRST`=1, an active software rule beats any active hardware rule. With `SW_FIRST`=0, an active hardware rule beats any active software rule.
- R2: Inside the software group, the priority order is: read side effect (`req_hit` with `req_is_wr`=0), then the write rule (`req_hit` with `req_is_wr`=1), then the pulse rule.
- R3: Inside the hardware group, the priority order is: `hw_set` (field becomes all ones), then `hw_clr` (field becomes zero), then the hardware data write path.
- R4: On a write, `WR_KIND` acts only on field bits whose bit enable is 1. Disabled bits keep their value. For enabled bit `b` with data `d`, the rules are:
  - WK_PLAIN: result is `d`.
  - WK_SET: result is 1.
  - WK_CLR: result is 0.
  - WK_W1S, WK_W1C, WK_W1T: set, clear or toggle when `d`=1.
  - WK_W0S, WK_W0C, WK_W0T: set, clear or toggle when `d`=0.
  - WK_NONE: no write rule is active.
- R5: On a read, `RD_KIND`=RK_CLR loads zero and RK_SET loads all ones. RK_NONE makes reads have no effect on the field.
- R6: The hardware data write loads `hw_next` under these conditions:
  - HE_WE: when `hw_we`=1.
  - HE_WEL: when `hw_wel`=0.
  - HE_ALWAYS: every cycle.
  - HE_NONE: never.
- R7: When no rule is active, the field holds its value.
- R8: With `PULSE`=1, a nonzero field returns to zero on the next cycle unless a higher rule wins. A written one is therefore high for exactly one cycle.
- R9: `acc_stb` equals `req_hit`. `rd_acc_stb` is `req_hit` with `req_is_wr`=0. `wr_acc_stb` is `req_hit` with `req_is_wr`=1.
- R10: `mod_stb` is 1 in two cases:
  - on a read access when `RD_KIND`≠RK_NONE;
  - on a write access when `WR_KIND`≠WK_NONE and at least one field bit enable is 1.
  It is 0 otherwise.
- R11: The field slice is taken as follows. With `BIT_REV`=0, field bit i comes from bus bit `FLD_LSB`+i. With `BIT_REV`=1, the bus is bit-reversed first, so field bit i comes from bus bit `DATA_W`-1-(`FLD_LSB`+i).
- R12: While `rst_n`=0, the field holds `RST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_hit | input | 1 | Decoded access to this field's register |
| req_is_wr | input | 1 | Access is a write (1) or a read (0) |
| wr_data | input | DATA_W | Write data bus |
| wr_biten | input | DATA_W | Write bit enables |
| hw_next | input | FLD_W | Hardware write value |
| hw_we | input | 1 | Active-high hardware write enable |
| hw_wel | input | 1 | Active-low hardware write enable |
| hw_set | input | 1 | Hardware set to all ones |
| hw_clr | input | 1 | Hardware clear to zero |
| fld_q | output | FLD_W | Stored field value |
| acc_stb | output | 1 | Any software access |
| rd_acc_stb | output | 1 | Software read access |
| wr_acc_stb | output | 1 | Software write access |
| mod_stb | output | 1 | Software modified the field |

## Verification
Twelve instances share one stimulus stream:
- one with clear-on-read and software precedence;
- one with set-on-read, write-one-clear, an active-low enable, hardware precedence and reversed bit order;
- one in pulse mode with an always-on hardware write;
- nine covering every write rule.

Random mixes of reads, writes with partial bit enables, and overlapping hardware set, clear and write separate the group order from the order within each group. Writes with all enables off separate a rule that wins and holds the value from one that is inactive. The reversed instance, fed the same data as the others, shows whether the slice is taken from the mirrored positions.

// File: rtl/fld_pkg.sv
package fld_pkg;

    // Software write rule applied to enabled bits
    typedef enum logic [3:0] {
        WK_NONE,
        WK_PLAIN,
        WK_SET,
        WK_CLR,
        WK_W0T,
        WK_W0C,
        WK_W0S,
        WK_W1T,
        WK_W1C,
        WK_W1S
    } fld_wr_e;

    // Side effect of a software read
    typedef enum logic [1:0] {
        RK_NONE,
        RK_CLR,
        RK_SET
    } fld_rd_e;

    // Qualification of the hardware data write
    typedef enum logic [1:0] {
        HE_NONE,
        HE_WE,
        HE_WEL,
        HE_ALWAYS
    } fld_hwen_e;

    // Rule source selected for the next value
    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_RDFX,
        SRC_WRITE,
        SRC_PULSE,
        SRC_HSET,
        SRC_HCLR,
        SRC_HWR
    } upd_src_e;

endpackage

// File: rtl/fld_bus_slice.sv
module fld_bus_slice #(
    parameter int DATA_W  = 16,
    parameter int FLD_W   = 4,
    parameter int FLD_LSB = 3,
    parameter bit BIT_REV = 1'b0
) (
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_biten,
    output logic [FLD_W-1:0]  fld_d,
    output logic [FLD_W-1:0]  fld_b
);
    localparam int TOP_IDX = FLD_LSB + FLD_W - 1;

    // Bits outside the slice are intentionally not consumed
    logic unused_bus;
    assign unused_bus = ^{wr_data, wr_biten};

    generate
        if (BIT_REV) begin : g_rev
            for (genvar i = 0; i < FLD_W; i++) begin : g_bit
                assign fld_d[i] = wr_data[DATA_W-1-(FLD_LSB+i)];
                assign fld_b[i] = wr_biten[DATA_W-1-(FLD_LSB+i)];
            end
        end else begin : g_fwd
            assign fld_d = wr_data[TOP_IDX:FLD_LSB];
            assign fld_b = wr_biten[TOP_IDX:FLD_LSB];
        end
    endgenerate
endmodule

// File: rtl/fld_sw_group.sv
module fld_sw_group
    import fld_pkg::*;
#(
    parameter int      FLD_W   = 4,
    parameter fld_wr_e WR_KIND = WK_PLAIN,
    parameter fld_rd_e RD_KIND = RK_CLR,
    parameter bit      PULSE   = 1'b0
) (
    input  logic             req_hit,
    input  logic             req_is_wr,
    input  logic [FLD_W-1:0] cur_q,
    input  logic [FLD_W-1:0] fld_d,
    input  logic [FLD_W-1:0] fld_b,
    output logic             sw_act,
    output upd_src_e         sw_src,
    output logic [FLD_W-1:0] sw_val
);
    localparam bit HAS_RD = (RD_KIND != RK_NONE);
    localparam bit HAS_WR = (WR_KIND != WK_NONE);

    logic             rd_fx;
    logic             wr_on;
    logic             pulse_on;
    logic [FLD_W-1:0] wr_res;

    assign rd_fx    = HAS_RD && req_hit && !req_is_wr;
    assign wr_on    = HAS_WR && req_hit && req_is_wr;
    assign pulse_on = PULSE && (|cur_q);

    // Per-bit write rule, masked by bit enables
    always_comb begin
        wr_res = cur_q;
        unique case (WR_KIND)
            WK_PLAIN: wr_res = (cur_q & ~fld_b) | (fld_d & fld_b);
            WK_SET:   wr_res = cur_q | fld_b;
            WK_CLR:   wr_res = cur_q & ~fld_b;
            WK_W1S:   wr_res = cur_q | (fld_d & fld_b);
            WK_W1C:   wr_res = cur_q & ~(fld_d & fld_b);
            WK_W1T:   wr_res = cur_q ^ (fld_d & fld_b);
            WK_W0S:   wr_res = cur_q | (~fld_d & fld_b);
            WK_W0C:   wr_res = cur_q & ~(~fld_d & fld_b);
            WK_W0T:   wr_res = cur_q ^ (~fld_d & fld_b);
            default:  wr_res = cur_q;
        endcase
    end

    // Fixed order: read effect, write rule, pulse
    always_comb begin
        if (rd_fx)         sw_src = SRC_RDFX;
        else if (wr_on)    sw_src = SRC_WRITE;
        else if (pulse_on) sw_src = SRC_PULSE;
        else               sw_src = SRC_HOLD;
    end

    assign sw_act = (sw_src != SRC_HOLD);

    always_comb begin
        unique case (sw_src)
            SRC_RDFX:  sw_val = (RD_KIND == RK_SET) ? '1 : '0;
            SRC_WRITE: sw_val = wr_res;
            SRC_PULSE: sw_val = '0;
            default:   sw_val = cur_q;
        endcase
    end
endmodule

// File: rtl/fld_hw_group.sv
module fld_hw_group
    import fld_pkg::*;
#(
    parameter int        FLD_W = 4,
    parameter fld_hwen_e HW_EN = HE_WE
) (
    input  logic             hw_set,
    input  logic             hw_clr,
    input  logic             hw_we,
    input  logic             hw_wel,
    input  logic [FLD_W-1:0] hw_next,
    input  logic [FLD_W-1:0] cur_q,
    output logic             hw_act,
    output upd_src_e         hw_src,
    output logic [FLD_W-1:0] hw_val
);
    logic hwr_on;

    always_comb begin
        unique case (HW_EN)
            HE_WE:     hwr_on = hw_we;
            HE_WEL:    hwr_on = !hw_wel;
            HE_ALWAYS: hwr_on = 1'b1;
            default:   hwr_on = 1'b0;
        endcase
    end

    // Fixed order: set, clear, data write
    always_comb begin
        if (hw_set)      hw_src = SRC_HSET;
        else if (hw_clr) hw_src = SRC_HCLR;
        else if (hwr_on) hw_src = SRC_HWR;
        else             hw_src = SRC_HOLD;
    end

    assign hw_act = (hw_src != SRC_HOLD);

    always_comb begin
        unique case (hw_src)
            SRC_HSET: hw_val = '1;
            SRC_HCLR: hw_val = '0;
            SRC_HWR:  hw_val = hw_next;
            default:  hw_val = cur_q;
        endcase
    end
endmodule

// File: rtl/fld_strobes.sv
module fld_strobes
    import fld_pkg::*;
#(
    parameter int      FLD_W   = 4,
    parameter fld_wr_e WR_KIND = WK_PLAIN,
    parameter fld_rd_e RD_KIND = RK_CLR
) (
    input  logic             req_hit,
    input  logic             req_is_wr,
    input  logic [FLD_W-1:0] fld_b,
    output logic             acc_stb,
    output logic             rd_acc_stb,
    output logic             wr_acc_stb,
    output logic             mod_stb
);
    localparam bit RD_MOD = (RD_KIND != RK_NONE);
    localparam bit WR_MOD = (WR_KIND != WK_NONE);

    assign acc_stb    = req_hit;
    assign rd_acc_stb = req_hit && !req_is_wr;
    assign wr_acc_stb = req_hit && req_is_wr;

    generate
        if (!RD_MOD && !WR_MOD) begin : g_nomod
            logic unused_b;
            assign unused_b = ^fld_b;
            assign mod_stb  = 1'b0;
        end else begin : g_mod
            assign mod_stb = (RD_MOD && rd_acc_stb) ||
                             (WR_MOD && wr_acc_stb && (|fld_b));
        end
    endgenerate
endmodule

// File: rtl/prio_field.sv
module prio_field
    import fld_pkg::*;
#(
    parameter int              DATA_W   = 16,
    parameter int              FLD_W    = 4,
    parameter int              FLD_LSB  = 3,
    parameter bit              BIT_REV  = 1'b0,
    parameter fld_wr_e         WR_KIND  = WK_PLAIN,
    parameter fld_rd_e         RD_KIND  = RK_CLR,
    parameter bit              PULSE    = 1'b0,
    parameter fld_hwen_e       HW_EN    = HE_WE,
    parameter bit              SW_FIRST = 1'b1,
    parameter logic [FLD_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_hit,
    input  logic              req_is_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_biten,
    input  logic [FLD_W-1:0]  hw_next,
    input  logic              hw_we,
    input  logic              hw_wel,
    input  logic              hw_set,
    input  logic              hw_clr,
    output logic [FLD_W-1:0]  fld_q,
    output logic              acc_stb,
    output logic              rd_acc_stb,
    output logic              wr_acc_stb,
    output logic              mod_stb
);
    logic [FLD_W-1:0] fld_d;
    logic [FLD_W-1:0] fld_b;
    logic             sw_act;
    logic             hw_act;
    upd_src_e         sw_src;
    upd_src_e         hw_src;
    upd_src_e         win_src;
    logic [FLD_W-1:0] sw_val;
    logic [FLD_W-1:0] hw_val;
    logic [FLD_W-1:0] nxt_q;

    fld_bus_slice #(
        .DATA_W (DATA_W),
        .FLD_W  (FLD_W),
        .FLD_LSB(FLD_LSB),
        .BIT_REV(BIT_REV)
    ) u_slice (
        .wr_data (wr_data),
        .wr_biten(wr_biten),
        .fld_d   (fld_d),
        .fld_b   (fld_b)
    );

    fld_sw_group #(
        .FLD_W  (FLD_W),
        .WR_KIND(WR_KIND),
        .RD_KIND(RD_KIND),
        .PULSE  (PULSE)
    ) u_sw (
        .req_hit  (req_hit),
        .req_is_wr(req_is_wr),
        .cur_q    (fld_q),
        .fld_d    (fld_d),
        .fld_b    (fld_b),
        .sw_act   (sw_act),
        .sw_src   (sw_src),
        .sw_val   (sw_val)
    );

    fld_hw_group #(
        .FLD_W(FLD_W),
        .HW_EN(HW_EN)
    ) u_hw (
        .hw_set (hw_set),
        .hw_clr (hw_clr),
        .hw_we  (hw_we),
        .hw_wel (hw_wel),
        .hw_next(hw_next),
        .cur_q  (fld_q),
        .hw_act (hw_act),
        .hw_src (hw_src),
        .hw_val (hw_val)
    );

    fld_strobes #(
        .FLD_W  (FLD_W),
        .WR_KIND(WR_KIND),
        .RD_KIND(RD_KIND)
    ) u_stb (
        .req_hit   (req_hit),
        .req_is_wr (req_is_wr),
        .fld_b     (fld_b),
        .acc_stb   (acc_stb),
        .rd_acc_stb(rd_acc_stb),
        .wr_acc_stb(wr_acc_stb),
        .mod_stb   (mod_stb)
    );

    // Group arbitration by precedence
    always_comb begin
        if (SW_FIRST) win_src = sw_act ? sw_src : hw_src;
        else          win_src = hw_act ? hw_src : sw_src;
    end

    // Next value of the winning source
    always_comb begin
        unique case (win_src)
            SRC_RDFX, SRC_WRITE, SRC_PULSE: nxt_q = sw_val;
            SRC_HSET, SRC_HCLR, SRC_HWR:    nxt_q = hw_val;
            default:                        nxt_q = fld_q;
        endcase
    end

    // Field storage
    always_ff @(posedge clk) begin
        if (!rst_n) fld_q <= RST_VAL;
        else        fld_q <= nxt_q;
    end
endmodule

// File: rtl/prio_field_chk.sv
module prio_field_chk
    import fld_pkg::*;
#(
    parameter int        FLD_W    = 4,
    parameter fld_rd_e   RD_KIND  = RK_CLR,
    parameter bit        PULSE    = 1'b0,
    parameter fld_hwen_e HW_EN    = HE_WE,
    parameter bit        SW_FIRST = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_hit,
    input logic             req_is_wr,
    input logic             hw_we,
    input logic             hw_wel,
    input logic             hw_set,
    input logic             hw_clr,
    input logic [FLD_W-1:0] fld_q,
    input logic             acc_stb,
    input logic             rd_acc_stb,
    input logic             wr_acc_stb,
    input logic             mod_stb
);
    logic hw_path;
    always_comb begin
        case (HW_EN)
            HE_WE:     hw_path = hw_we;
            HE_WEL:    hw_path = !hw_wel;
            HE_ALWAYS: hw_path = 1'b1;
            default:   hw_path = 1'b0;
        endcase
    end

    // R9
    strobe_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> (rd_acc_stb ^ wr_acc_stb));

    // R9
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_hit |-> (!acc_stb && !rd_acc_stb && !wr_acc_stb));

    // R10
    mod_needs_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stb |-> acc_stb);

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_hit && !hw_set && !hw_clr && !hw_path && !(PULSE && (|fld_q)))
        |=> $stable(fld_q));

    generate
        if (!SW_FIRST) begin : g_hwfirst
            // R3
            hwset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hw_set |=> (fld_q == '1));
        end
        if (SW_FIRST && RD_KIND == RK_CLR) begin : g_rdclr
            // R5
            rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (req_hit && !req_is_wr) |=> (fld_q == '0));
        end
        if (SW_FIRST && PULSE) begin : g_pulse
            // R8
            pulse_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((|fld_q) && !req_hit) |=> (fld_q == '0));
        end
    endgenerate
endmodule

bind prio_field prio_field_chk #(
    .FLD_W   (FLD_W),
    .RD_KIND (RD_KIND),
    .PULSE   (PULSE),
    .HW_EN   (HW_EN),
    .SW_FIRST(SW_FIRST)
) u_prio_field_chk (.*);

// File: tb/test_prio_field.sv
module test_prio_field;
    import fld_pkg::*;

    localparam int NI = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_hit = 1'b0;
    logic        req_is_wr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] wr_biten = '0;
    logic [3:0]  hw_next = '0;
    logic        hw_we = 1'b0;
    logic        hw_wel = 1'b1;
    logic        hw_set = 1'b0;
    logic        hw_clr = 1'b0;

    logic [3:0] q_o   [NI];
    logic       acc_o [NI];
    logic       rd_o  [NI];
    logic       wr_o  [NI];
    logic       mod_o [NI];

    int c_wk [NI];
    int c_rk [NI];
    int c_pl [NI];
    int c_he [NI];
    int c_sf [NI];
    int c_rev[NI];
    logic [3:0] c_rst[NI];
    logic [3:0] mq[NI];

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    prio_field #(
        .DATA_W(16), .FLD_W(4), .FLD_LSB(3), .BIT_REV(1'b0),
        .WR_KIND(WK_PLAIN), .RD_KIND(RK_CLR), .PULSE(1'b0),
        .HW_EN(HE_WE), .SW_FIRST(1'b1), .RST_VAL(4'h5)
    ) i_prio_field (
        .clk(clk), .rst_n(rst_n), .req_hit(req_hit), .req_is_wr(req_is_wr),
        .wr_data(wr_data), .wr_biten(wr_biten), .hw_next(hw_next),
        .hw_we(hw_we), .hw_wel(hw_wel), .hw_set(hw_set), .hw_clr(hw_clr),
        .fld_q(q_o[0]), .acc_stb(acc_o[0]), .rd_acc_stb(rd_o[0]),
        .wr_acc_stb(wr_o[0]), .mod_stb(mod_o[0])
    );

    prio_field #(
        .DATA_W(16), .FLD_W(4), .FLD_LSB(3), .BIT_REV(1'b1),
        .WR_KIND(WK_W1C), .RD_KIND(RK_SET), .PULSE(1'b0),
        .HW_EN(HE_WEL), .SW_FIRST(1'b0), .RST_VAL(4'h0)
    ) i_prio_field_rev (
        .clk(clk), .rst_n(rst_n), .req_hit(req_hit), .req_is_wr(req_is_wr),
        .wr_data(wr_data), .wr_biten(wr_biten), .hw_next(hw_next),
        .hw_we(hw_we), .hw_wel(hw_wel), .hw_set(hw_set), .hw_clr(hw_clr),
        .fld_q(q_o[1]), .acc_stb(acc_o[1]), .rd_acc_stb(rd_o[1]),
        .wr_acc_stb(wr_o[1]), .mod_stb(mod_o[1])
    );

    prio_field #(
        .DATA_W(16), .FLD_W(4), .FLD_LSB(3), .BIT_REV(1'b0),
        .WR_KIND(WK_PLAIN), .RD_KIND(RK_NONE), .PULSE(1'b1),
        .HW_EN(HE_ALWAYS), .SW_FIRST(1'b1), .RST_VAL(4'h0)
    ) i_prio_field_pls (
        .clk(clk), .rst_n(rst_n), .req_hit(req_hit), .req_is_wr(req_is_wr),
        .wr_data(wr_data), .wr_biten(wr_biten), .hw_next(hw_next),
        .hw_we(hw_we), .hw_wel(hw_wel), .hw_set(hw_set), .hw_clr(hw_clr),
        .fld_q(q_o[2]), .acc_stb(acc_o[2]), .rd_acc_stb(rd_o[2]),
        .wr_acc_stb(wr_o[2]), .mod_stb(mod_o[2])
    );

    for (genvar k = 0; k < 9; k++) begin : g_wk
        prio_field #(
            .DATA_W(16), .FLD_W(4), .FLD_LSB(3), .BIT_REV(1'b0),
            .WR_KIND(fld_wr_e'(k + 1)), .RD_KIND(RK_NONE), .PULSE(1'b0),
            .HW_EN(HE_WE), .SW_FIRST(1'b1), .RST_VAL(4'h6)
        ) i_prio_field_wk (
            .clk(clk), .rst_n(rst_n), .req_hit(req_hit), .req_is_wr(req_is_wr),
            .wr_data(wr_data), .wr_biten(wr_biten), .hw_next(hw_next),
            .hw_we(hw_we), .hw_wel(hw_wel), .hw_set(hw_set), .hw_clr(hw_clr),
            .fld_q(q_o[3+k]), .acc_stb(acc_o[3+k]), .rd_acc_stb(rd_o[3+k]),
            .wr_acc_stb(wr_o[3+k]), .mod_stb(mod_o[3+k])
        );
    end

    task automatic check(input bit ok, input string tag, input int inst,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s inst=%0d actual=%0h expected=%0h", tag, inst, act, exp);
        end
    endtask

    // Field bit i taken from bus position per R11
    function automatic int bus_pos(input int rev, input int i);
        return rev ? (15 - (3 + i)) : (3 + i);
    endfunction

    // One enabled bit under a write rule (R4)
    function automatic bit wr_bit(input int wk, input bit q, input bit d);
        case (wk)
            1: return d;
            2: return 1'b1;
            3: return 1'b0;
            4: return d ? q : ~q;
            5: return d ? q : 1'b0;
            6: return d ? q : 1'b1;
            7: return d ? ~q : q;
            8: return d ? 1'b0 : q;
            9: return d ? 1'b1 : q;
            default: return q;
        endcase
    endfunction

    task automatic step();
        logic [3:0] fd, fb, nq;
        logic [3:0] expq[NI];
        string      tags[NI];
        #2;
        for (int i = 0; i < NI; i++) begin
            bit rdx, wrx, plx, hwr, swa, hwa, e_mod;
            int sw_cnt, hw_cnt;
            logic [3:0] swv, hwv;
            string t_sw, t_hw;
            for (int b = 0; b < 4; b++) begin
                fd[b] = wr_data[bus_pos(c_rev[i], b)];
                fb[b] = wr_biten[bus_pos(c_rev[i], b)];
            end
            e_mod = (req_hit && !req_is_wr && c_rk[i] != 0) ||
                    (req_hit && req_is_wr && c_wk[i] != 0 && fb != 0);
            check(acc_o[i] == req_hit, "R9 acc", i, acc_o[i], req_hit);
            check(rd_o[i] == (req_hit && !req_is_wr), "R9 rd", i, rd_o[i], req_hit && !req_is_wr);
            check(wr_o[i] == (req_hit && req_is_wr), "R9 wr", i, wr_o[i], req_hit && req_is_wr);
            check(mod_o[i] == e_mod, "R10 mod", i, mod_o[i], e_mod);

            rdx = req_hit && !req_is_wr && c_rk[i] != 0;
            wrx = req_hit && req_is_wr && c_wk[i] != 0;
            plx = c_pl[i] != 0 && mq[i] != 0;
            case (c_he[i])
                1: hwr = hw_we;
                2: hwr = !hw_wel;
                3: hwr = 1'b1;
                default: hwr = 1'b0;
            endcase
            sw_cnt = rdx + wrx + plx;
            hw_cnt = hw_set + hw_clr + hwr;
            swa = sw_cnt != 0;
            hwa = hw_cnt != 0;
            if (rdx) begin
                swv = (c_rk[i] == 2) ? 4'hF : 4'h0; t_sw = "R5";
            end else if (wrx) begin
                for (int b = 0; b < 4; b++)
                    swv[b] = fb[b] ? wr_bit(c_wk[i], mq[i][b], fd[b]) : mq[i][b];
                t_sw = c_rev[i] ? "R11" : "R4";
            end else begin
                swv = 4'h0; t_sw = "R8";
            end
            if (sw_cnt > 1) t_sw = "R2";
            if (hw_set)      begin hwv = 4'hF;    t_hw = "R3"; end
            else if (hw_clr) begin hwv = 4'h0;    t_hw = "R3"; end
            else             begin hwv = hw_next; t_hw = "R6"; end
            if (hw_cnt > 1) t_hw = "R3";
            if (swa && (c_sf[i] != 0 || !hwa)) begin nq = swv; tags[i] = t_sw; end
            else if (hwa)                      begin nq = hwv; tags[i] = t_hw; end
            else                               begin nq = mq[i]; tags[i] = "R7"; end
            if (swa && hwa) tags[i] = "R1";
            expq[i] = nq;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NI; i++) begin
            check(q_o[i] == expq[i], tags[i], i, q_o[i], expq[i]);
            mq[i] = expq[i];
        end
    endtask

    task automatic drive(input bit hit, input bit wr, input logic [15:0] d,
                         input logic [15:0] be, input bit s, input bit c,
                         input bit we, input bit wel, input logic [3:0] hn);
        @(negedge clk);
        req_hit = hit; req_is_wr = wr; wr_data = d; wr_biten = be;
        hw_set = s; hw_clr = c; hw_we = we; hw_wel = wel; hw_next = hn;
        step();
    endtask

    initial begin
        for (int i = 0; i < NI; i++) begin
            c_wk[i] = 1; c_rk[i] = 0; c_pl[i] = 0; c_he[i] = 1;
            c_sf[i] = 1; c_rev[i] = 0; c_rst[i] = 4'h6;
        end
        c_rk[0] = 1; c_rst[0] = 4'h5;
        c_wk[1] = 8; c_rk[1] = 2; c_he[1] = 2; c_sf[1] = 0; c_rev[1] = 1; c_rst[1] = 4'h0;
        c_pl[2] = 1; c_he[2] = 3; c_rst[2] = 4'h0;
        for (int k = 0; k < 9; k++) c_wk[3+k] = k + 1;

        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < NI; i++) begin
            check(q_o[i] == c_rst[i], "R12 reset", i, q_o[i], c_rst[i]);
            mq[i] = c_rst[i];
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Idle hold (R7)
        drive(0, 0, 16'h0, 16'h0, 0, 0, 0, 1, 4'h0);
        // Plain write of all ones in field slice (R4)
        drive(1, 1, 16'hFFFF, 16'h0078, 0, 0, 0, 1, 4'h0);
        // Write with no enabled bits
        drive(1, 1, 16'h0000, 16'h0000, 0, 0, 0, 1, 4'h0);
        // Read against simultaneous hw write (R1, R5)
        drive(1, 0, 16'h0, 16'h0, 0, 0, 1, 0, 4'h9);
        // Hw set and clear together (R3)
        drive(0, 0, 16'h0, 16'h0, 1, 1, 1, 0, 4'h3);
        // Hw clear beats hw write (R3)
        drive(0, 0, 16'h0, 16'h0, 0, 1, 1, 0, 4'hC);
        // Hw write only (R6)
        drive(0, 0, 16'h0, 16'h0, 0, 0, 1, 1, 4'hA);
        // Reversed-order slice write (R11)
        drive(1, 1, 16'h0F00, 16'h0F00, 0, 0, 0, 1, 4'h0);

        for (int n = 0; n < 3000; n++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 1),
                  16'($urandom), 16'($urandom),
                  $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                  $urandom_range(0, 1), $urandom_range(0, 1),
                  4'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule